// File: doc/BRIEF.md
# Per-Block Lock State Controller

This block holds the protection state of every erase block of a flash-style memory array. Each block is unlocked, locked, or locked-down. A command front end forwards bus write cycles carrying an 8-bit code and a block index. A two-write sequence, a setup code followed by a confirm code, changes the protection of the addressed block. A write-protect input decides whether a locked-down block may be released.

The program and erase path asks the block, one request at a time, whether a target block may be written. It gets an allow or a reject answer in the same cycle. The reject answer is the block-locked status bit (status bit 1) that the status logic latches. A separate read port returns the 2-bit state of any block for status reads.

A locked-down block that was released while write-protect was deasserted keeps a hidden re-arm mark. A later lock command returns it straight to locked-down, but any change of the write-protect input clears that mark first.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset every block reads state 2'b01 (locked, not locked-down), and no block keeps a re-arm mark: a lock applied after reset gives 2'b01.
- R2: A write of 0x60 followed by a write of 0x01 locks the block given with the confirm write. The new state shows on rd_state and on the check port in the cycle after the confirm write; there is no further delay.
- R3: 0x60 followed by 0xD0 turns a locked block unlocked, read as 2'b00.
- R4: 0x60 followed by 0x2F makes the block locked-down, read as 2'b11, from any state. A later lock command leaves a locked-down block at 2'b11.
- R5: An unlock of a locked-down block while wprot is 0 gives 2'b00.
- R6: An unlock of a locked-down block while wprot is 1 is ignored: the block stays at 2'b11 and is still rejected.
- R7: A block released from locked-down returns to 2'b11 on a lock command if wprot has not changed since the release. If wprot changed in between, the lock command gives 2'b01.
- R8: With chk_valid high, chk_allow is 1 for an unlocked block and chk_reject (block-locked status bit 1) is 1 for a locked or locked-down block, both in the same cycle. With chk_valid low, both are 0.
- R9: After a setup write, a write whose code is not 0x01, 0xD0 or 0x2F pulses seq_err in that cycle, changes no state and returns the sequencer to idle. Codes other than 0x60 written while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command write cycle strobe |
| wr_code | input | 8 | Command code of the write cycle |
| wr_blk | input | BLK_AW | Block index of the write cycle |
| wprot | input | 1 | Write-protect, 1 = asserted |
| rd_blk | input | BLK_AW | Block whose state is read out |
| rd_state | output | 2 | Bit 0 locked, bit 1 locked-down |
| chk_valid | input | 1 | Program/erase permission request |
| chk_blk | input | BLK_AW | Target block of the request |
| chk_allow | output | 1 | Request may proceed |
| chk_reject | output | 1 | Request refused; block-locked status bit 1 |
| seq_err | output | 1 | Setup followed by an invalid confirm code |

## Verification
On every cycle the assertions check the result of each applied operation on its target block: lock never leaves a block writable, lock-down always lands in locked-down, and unlock of a locked-down block follows the write-protect level. They also check that a sequence error leaves all states untouched and that the check port answers exactly one of allow or reject for a valid request. Only the bench scenarios show the history-dependent paths: the hidden re-arm mark surviving an unchanged write-protect and being lost after a toggle, codes ignored while idle, and the all-locked state after a reset in the middle of a run.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  // Internal state; bit 0 of the readout is "locked", bit 1 "locked-down"
  typedef enum logic [1:0] {
    LS_UNLOCKED = 2'd0,
    LS_LOCKED   = 2'd1,
    LS_REARM    = 2'd2,   // unlocked, but lock returns it to locked-down
    LS_DOWN     = 2'd3
  } lk_state_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_DOWN   = 2'd3
  } lk_op_t;

  localparam logic [7:0] CODE_SETUP  = 8'h60;
  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_DOWN   = 8'h2F;

  function automatic lk_op_t decode_confirm(input logic [7:0] code);
    lk_op_t r;
    case (code)
      CODE_LOCK:   r = OP_LOCK;
      CODE_UNLOCK: r = OP_UNLOCK;
      CODE_DOWN:   r = OP_DOWN;
      default:     r = OP_NONE;
    endcase
    return r;
  endfunction

  // Next state of one block given the applied operation and protect events
  function automatic lk_state_t step(input lk_state_t s, input lk_op_t op,
                                     input logic wp_on, input logic wp_chg);
    lk_state_t b;
    lk_state_t r;
    b = (wp_chg && (s == LS_REARM)) ? LS_UNLOCKED : s;
    r = b;
    case (op)
      OP_LOCK: begin
        if (b == LS_UNLOCKED)   r = LS_LOCKED;
        else if (b == LS_REARM) r = LS_DOWN;
      end
      OP_UNLOCK: begin
        if (b == LS_LOCKED)                r = LS_UNLOCKED;
        else if (b == LS_DOWN && !wp_on)   r = LS_REARM;
      end
      OP_DOWN: r = LS_DOWN;
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] state_bits(input lk_state_t s);
    return {s == LS_DOWN, (s == LS_LOCKED) || (s == LS_DOWN)};
  endfunction

  function automatic logic writable(input lk_state_t s);
    return (s == LS_UNLOCKED) || (s == LS_REARM);
  endfunction

endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
  import blk_lock_pkg::*;
#(
  parameter int BLK_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_code,
  input  logic [BLK_AW-1:0] wr_blk,
  output lk_op_t            op,
  output logic [BLK_AW-1:0] op_blk,
  output logic              seq_err
);

  logic armed_q;

  always_comb begin
    op      = OP_NONE;
    seq_err = 1'b0;
    if (wr_valid && armed_q) begin
      op      = decode_confirm(wr_code);
      seq_err = (decode_confirm(wr_code) == OP_NONE);
    end
  end

  assign op_blk = wr_blk;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (wr_valid) armed_q <= armed_q ? 1'b0 : (wr_code == CODE_SETUP);
  end

endmodule

// File: rtl/blk_lock_wpmon.sv
module blk_lock_wpmon (
  input  logic clk,
  input  logic rst_n,
  input  logic wprot,
  output logic wp_chg
);

  logic wprot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wprot_q <= 1'b0;
    else        wprot_q <= wprot;
  end

  assign wp_chg = wprot ^ wprot_q;

endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
  import blk_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  lk_op_t    op,
  input  logic      wp_on,
  input  logic      wp_chg,
  output lk_state_t state
);

  lk_state_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LS_LOCKED;
    else        state_q <= step(state_q, sel ? op : OP_NONE, wp_on, wp_chg);
  end

  assign state = state_q;

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_AW     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_code,
  input  logic [BLK_AW-1:0] wr_blk,
  input  logic              wprot,
  input  logic [BLK_AW-1:0] rd_blk,
  output logic [1:0]        rd_state,
  input  logic              chk_valid,
  input  logic [BLK_AW-1:0] chk_blk,
  output logic              chk_allow,
  output logic              chk_reject,
  output logic              seq_err
);

  lk_op_t                  op;
  logic [BLK_AW-1:0]       op_blk;
  logic                    wp_chg;
  lk_state_t               blk_st [NUM_BLOCKS];
  logic [2*NUM_BLOCKS-1:0] st_flat;
  lk_state_t               rd_sel;
  lk_state_t               chk_sel;

  blk_lock_seq #(.BLK_AW(BLK_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
    .wr_blk(wr_blk), .op(op), .op_blk(op_blk), .seq_err(seq_err)
  );

  blk_lock_wpmon u_wp (
    .clk(clk), .rst_n(rst_n), .wprot(wprot), .wp_chg(wp_chg)
  );

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
    blk_lock_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sel(op_blk == BLK_AW'(i)), .op(op),
      .wp_on(wprot), .wp_chg(wp_chg), .state(blk_st[i])
    );
    assign st_flat[2*i +: 2] = blk_st[i];
  end

  // Out-of-range indices read as locked
  always_comb begin
    rd_sel  = LS_LOCKED;
    chk_sel = LS_LOCKED;
    for (int k = 0; k < NUM_BLOCKS; k++) begin
      if (rd_blk  == BLK_AW'(k)) rd_sel  = blk_st[k];
      if (chk_blk == BLK_AW'(k)) chk_sel = blk_st[k];
    end
  end

  assign rd_state   = state_bits(rd_sel);
  assign chk_allow  = chk_valid &&  writable(chk_sel);
  assign chk_reject = chk_valid && !writable(chk_sel);

endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_AW     = $clog2(NUM_BLOCKS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input lk_op_t                  op,
  input logic [BLK_AW-1:0]       op_blk,
  input logic                    seq_err,
  input logic                    wp_chg,
  input logic                    wprot,
  input logic [2*NUM_BLOCKS-1:0] st_flat,
  input logic                    chk_valid,
  input logic [BLK_AW-1:0]       chk_blk,
  input logic                    chk_allow,
  input logic                    chk_reject
);

  function automatic lk_state_t pick(input logic [2*NUM_BLOCKS-1:0] f,
                                     input logic [BLK_AW-1:0] idx);
    lk_state_t r;
    r = LS_LOCKED;
    for (int k = 0; k < NUM_BLOCKS; k++)
      if (idx == BLK_AW'(k)) r = lk_state_t'(f[2*k +: 2]);
    return r;
  endfunction

  lk_op_t            op_d;
  logic [BLK_AW-1:0] blk_d;
  logic              wpon_d;
  lk_state_t         pre_d;
  lk_state_t         cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_d   <= OP_NONE;
      blk_d  <= '0;
      wpon_d <= 1'b0;
      pre_d  <= LS_LOCKED;
    end else begin
      op_d   <= op;
      blk_d  <= op_blk;
      wpon_d <= wprot;
      pre_d  <= pick(st_flat, op_blk);
    end
  end

  assign cur = pick(st_flat, blk_d);

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_LOCK) |-> !writable(cur));

  assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_UNLOCK && pre_d == LS_LOCKED) |-> (cur == LS_UNLOCKED));

  assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_DOWN) |-> (cur == LS_DOWN));

  assert_down_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_UNLOCK && pre_d == LS_DOWN && !wpon_d) |-> writable(cur));

  assert_wp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_UNLOCK && pre_d == LS_DOWN && wpon_d) |-> (cur == LS_DOWN));

  assert_chk_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_allow != chk_reject));

  assert_chk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> (!chk_allow && !chk_reject));

  assert_chk_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !writable(pick(st_flat, chk_blk))) |-> chk_reject);

  assert_seq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !wp_chg) |=> $stable(st_flat));

endmodule

bind blk_lock_ctrl blk_lock_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .op_blk(op_blk), .seq_err(seq_err),
  .wp_chg(wp_chg), .wprot(wprot), .st_flat(st_flat), .chk_valid(chk_valid),
  .chk_blk(chk_blk), .chk_allow(chk_allow), .chk_reject(chk_reject)
);

// File: tb/sim_blk_lock_ctrl.sv
module sim_blk_lock_ctrl;

  localparam int NB = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_code = 8'h00;
  logic [AW-1:0] wr_blk = '0;
  logic          wprot = 1'b0;
  logic [AW-1:0] rd_blk = '0;
  logic [1:0]    rd_state;
  logic          chk_valid = 1'b0;
  logic [AW-1:0] chk_blk = '0;
  logic          chk_allow;
  logic          chk_reject;
  logic          seq_err;

  int total = 0;
  int bad   = 0;
  logic last_err;

  always #5 clk = ~clk;

  blk_lock_ctrl #(.NUM_BLOCKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
    .wr_blk(wr_blk), .wprot(wprot), .rd_blk(rd_blk), .rd_state(rd_state),
    .chk_valid(chk_valid), .chk_blk(chk_blk), .chk_allow(chk_allow),
    .chk_reject(chk_reject), .seq_err(seq_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input int blk);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_code  = code;
    wr_blk   = AW'(blk);
    #1 last_err = seq_err;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] code, input int blk);
    wr(8'h60, blk);
    wr(code, blk);
  endtask

  task automatic expect_state(input string tag, input int blk, input int exp);
    rd_blk = AW'(blk);
    #1 check(tag, int'(rd_state), exp);
  endtask

  task automatic expect_chk(input string tag, input int blk, input int allow);
    chk_valid = 1'b1;
    chk_blk   = AW'(blk);
    #1;
    check({tag, " allow"}, int'(chk_allow), allow);
    check({tag, " reject"}, int'(chk_reject), 1 - allow);
    chk_valid = 1'b0;
    #1;
    check({tag, " idle"}, int'({chk_allow, chk_reject}), 0);
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wprot = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int b = 0; b < NB; b++) expect_state("R1 reset state", b, 1);
    expect_chk("R8 locked after reset", 3, 0);
  endtask

  task automatic t_lock_unlock;
    cmd(8'hD0, 2);
    expect_state("R3 unlock", 2, 0);
    expect_chk("R8 unlocked block", 2, 1);
    expect_state("R3 neighbour untouched", 5, 1);
    cmd(8'h01, 2);
    expect_state("R2 lock no latency", 2, 1);
    expect_chk("R2 lock check", 2, 0);
  endtask

  task automatic t_lockdown;
    cmd(8'h2F, 4);
    expect_state("R4 down from locked", 4, 3);
    cmd(8'hD0, 6);
    cmd(8'h2F, 6);
    expect_state("R4 down from unlocked", 6, 3);
    cmd(8'h01, 6);
    expect_state("R4 lock keeps down", 6, 3);
    expect_chk("R8 down rejected", 4, 0);
  endtask

  task automatic t_wp_on;
    set_wp(1'b1);
    cmd(8'hD0, 4);
    expect_state("R6 unlock ignored", 4, 3);
    expect_chk("R6 still rejected", 4, 0);
  endtask

  task automatic t_wp_off;
    set_wp(1'b0);
    cmd(8'hD0, 4);
    expect_state("R5 release", 4, 0);
    expect_chk("R5 release allows", 4, 1);
  endtask

  task automatic t_relock;
    cmd(8'h01, 4);
    expect_state("R7 relock to down", 4, 3);
    cmd(8'hD0, 4);
    expect_state("R7 release again", 4, 0);
    set_wp(1'b1);
    set_wp(1'b0);
    cmd(8'h01, 4);
    expect_state("R7 lock after wp toggle", 4, 1);
  endtask

  task automatic t_seq_err;
    wr(8'h60, 7);
    wr(8'h55, 7);
    check("R9 bad confirm error", int'(last_err), 1);
    expect_state("R9 no change", 7, 1);
    wr(8'hD0, 7);
    check("R9 idle code no error", int'(last_err), 0);
    expect_state("R9 idle code ignored", 7, 1);
    wr(8'h60, 2);
    wr(8'h60, 2);
    check("R9 setup twice error", int'(last_err), 1);
    wr(8'hD0, 2);
    expect_state("R9 back to idle", 2, 1);
  endtask

  task automatic t_rerst;
    cmd(8'hD0, 9);
    cmd(8'h2F, 10);
    cmd(8'hD0, 10);
    expect_state("R5 pre-reset release", 10, 0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expect_state("R1 reset relocks", 9, 1);
    expect_state("R1 reset block 10", 10, 1);
    cmd(8'hD0, 10);
    cmd(8'h01, 10);
    expect_state("R1 rearm cleared", 10, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock_unlock();
    t_lockdown();
    t_wp_on();
    t_wp_off();
    t_relock();
    t_seq_err();
    t_rerst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule